// File: doc/BRIEF.md
# Backlight PWM Generator with Locked Shadow Registers

This block drives a display backlight pin with a pulse-width-modulated waveform. Software programs a control word and a period word through a simple write port. Each write lands in a shadow copy. The waveform generator only ever reads an active copy. Shadow contents move to the active copy when three conditions all hold: a change is pending, no lock is holding them back, and the running period has just ended. A status flag stays high from the write until that move has happened, so software can poll it after it releases the lock.

The period word sets a count of prescaled ticks and a bit count. The bit count splits the 16-bit duty field into an integer number of high ticks and a fraction. With fractional mode on, the fraction feeds a first-order accumulator that stretches some periods by one tick, so the average duty resolves below one tick. An initialisation strobe protects against a corrupted duty value. If the shadow duty is 0 or 1, the last saved good settings are restored, or fixed defaults when nothing has been saved. Otherwise the current shadow settings are saved.

Top module: `bl_pwm_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, `pwm_out` and `upd_pending` are 0.
- R2: A write to the control word (`wr_sel`=0) or the period word (`wr_sel`=1) makes `upd_pending` read 1 on the next cycle. It stays 1 until the shadow values have been copied to the active set.
- R3: While the group lock bit (bit 0 of the lock word, `wr_sel`=2) is set, the active settings do not change, `upd_pending` stays 1, and the output keeps its old duty.
- R4: When `master_lock` is high, transfers are blocked unless the ignore-master bit (bit 1 of the lock word) is set. When that bit is set, the transfer proceeds as if `master_lock` were low.
- R5: When the output is enabled, a pending transfer that is not blocked happens at the end of the current PWM period. When the output is disabled, it happens on the next prescaler tick. `upd_pending` falls in the same cycle as the transfer, and only on a cycle that has a prescaler tick.
- R6: The period word holds the period in bits [15:0] and the bit count `bc` in bits [19:16], where 0 means 16. The effective period P is the period masked to its low `bc` bits. A masked value of 0 means 2^bc-1. One PWM period lasts P ticks.
- R7: The control word holds the duty in bits [15:0], fractional enable in bit 30 and output enable in bit 31. With bit 31 clear, `pwm_out` is 0. With fractional mode off, each period is high for min(duty>>(16-bc), P) ticks.
- R8: With fractional mode on and integer part I < P, let F be the low 16-bc bits of the duty. Over any 2^(16-bc) consecutive periods, the total number of high ticks is 2^(16-bc)*I + F.
- R9: The prescaler produces one tick every `ref_div`+1 clocks, so every PWM time scales by that factor.
- R10: On `init_req`, if the shadow duty is 0 or 1, the shadow words are restored from the last saved pair, if one exists, and a transfer becomes pending. Otherwise the shadow pair is saved.
- R11: If `init_req` finds an invalid duty and nothing has been saved, the shadow words become 0xC000FA00 (control) and 0x000C0FA0 (period), which is full-on output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control word, 1 period word, 2 lock word |
| wr_data | input | 32 | Write data |
| init_req | input | 1 | Validate-and-restore / save strobe |
| master_lock | input | 1 | Chip-wide update lock |
| ref_div | input | PRE_W | Prescaler divide value (tick every ref_div+1 clocks) |
| pwm_out | output | 1 | Registered backlight PWM output |
| upd_pending | output | 1 | Shadow values not yet transferred |

## Verification
A wrong active-set copy shows up at the ports as a wrong count of high cycles within one PWM period after the transfer. Because of that, every configuration is checked by counting high cycles over whole periods, and for the dither over a full accumulator cycle of 2^(16-bc) periods. A lock or pending flag that is stuck or released too early shows up directly on `upd_pending`, and as a duty change while a lock is still held. Restore and default errors appear as a wrong duty one period after the strobe.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PER  = 2'd1,
    SEL_LOCK = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  // control word: bit31 enable, bit30 fractional, [15:0] duty
  typedef struct packed {
    logic        en;
    logic        frac;
    logic [15:0] duty;
  } ctrl_t;

  // period word: [19:16] bit count (0 -> 16), [15:0] period
  typedef struct packed {
    logic [3:0]  bc;
    logic [15:0] period;
  } per_t;

  localparam ctrl_t CTRL_DEF = '{en: 1'b1, frac: 1'b1, duty: 16'hFA00};
  localparam per_t  PER_DEF  = '{bc: 4'hC, period: 16'h0FA0};

endpackage

// File: rtl/bl_prescaler.sv
module bl_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] ref_div,
  output logic             tick
);
  logic [PRE_W-1:0] pre_cnt;

  assign tick = (pre_cnt >= ref_div);

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else if (tick) pre_cnt <= '0;
    else pre_cnt <= pre_cnt + 1'b1;
  end

  p_tick_spacing_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && ref_div != '0) |=> (!tick || ref_div == '0));

endmodule

// File: rtl/bl_shadow_bank.sv
module bl_shadow_bank
  import bl_pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        init_req,
  input  logic        master_lock,
  input  logic        tick,
  input  logic        boundary,
  output ctrl_t       act_ctrl,
  output per_t        act_per,
  output logic        pending
);
  ctrl_t sh_ctrl, sv_ctrl;
  per_t  sh_per, sv_per;
  logic  sv_valid, grp_lock, ign_master;
  logic  blocked, xfer, wr_val, duty_bad;
  logic  unused_wr_bits;
  sel_e  sel;

  assign sel            = sel_e'(wr_sel);
  assign unused_wr_bits = ^wr_data[29:20];
  assign blocked  = grp_lock || (master_lock && !ign_master);
  assign xfer     = pending && !blocked && (boundary || (tick && !act_ctrl.en));
  assign wr_val   = wr_en && (sel == SEL_CTRL || sel == SEL_PER);
  assign duty_bad = (sh_ctrl.duty <= 16'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_ctrl    <= '0;
      sh_per     <= '0;
      sv_ctrl    <= '0;
      sv_per     <= '0;
      sv_valid   <= 1'b0;
      act_ctrl   <= '0;
      act_per    <= '0;
      grp_lock   <= 1'b0;
      ign_master <= 1'b0;
      pending    <= 1'b0;
    end else begin
      if (xfer) begin
        act_ctrl <= sh_ctrl;
        act_per  <= sh_per;
      end
      if (wr_val || (init_req && !wr_en && duty_bad)) pending <= 1'b1;
      else if (xfer) pending <= 1'b0;

      if (wr_en) begin
        case (sel)
          SEL_CTRL: sh_ctrl <= '{en: wr_data[31], frac: wr_data[30], duty: wr_data[15:0]};
          SEL_PER:  sh_per  <= '{bc: wr_data[19:16], period: wr_data[15:0]};
          SEL_LOCK: begin
            grp_lock   <= wr_data[0];
            ign_master <= wr_data[1];
          end
          default: ;
        endcase
      end else if (init_req) begin
        if (duty_bad) begin
          sh_ctrl <= sv_valid ? sv_ctrl : CTRL_DEF;
          sh_per  <= sv_valid ? sv_per  : PER_DEF;
        end else begin
          sv_ctrl  <= sh_ctrl;
          sv_per   <= sh_per;
          sv_valid <= 1'b1;
        end
      end
    end
  end

  p_pend_set_r2: assert property (@(posedge clk) disable iff (rst)
    wr_val |=> pending);
  p_hold_locked_r3: assert property (@(posedge clk) disable iff (rst)
    grp_lock |=> ($stable(act_ctrl) && $stable(act_per)));
  p_master_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (master_lock && !ign_master) |=> ($stable(act_ctrl) && $stable(act_per)));
  p_no_xfer_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !pending |=> ($stable(act_ctrl) && $stable(act_per)));

endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  ctrl_t act_ctrl,
  input  per_t  act_per,
  output logic  boundary,
  output logic  pwm_out
);
  logic [15:0] cnt, acc, ipart, fpart, fmask;
  logic        dith, carry;
  logic [4:0]  bc, fw;
  logic [16:0] pmask, pm, peff, fsum, high;

  always_comb begin
    bc    = (act_per.bc == 4'd0) ? 5'd16 : {1'b0, act_per.bc};
    fw    = 5'd16 - bc;
    pmask = (17'd1 << bc) - 17'd1;
    pm    = {1'b0, act_per.period} & pmask;
    peff  = (pm == 17'd0) ? pmask : pm;
    fmask = (16'd1 << fw) - 16'd1;
    ipart = act_ctrl.duty >> fw;
    fpart = act_ctrl.duty & fmask;
    fsum  = {1'b0, acc} + {1'b0, fpart};
    carry = (fsum >= (17'd1 << fw));
    high  = {1'b0, ipart} + {16'd0, dith};
  end

  assign boundary = tick && ({1'b0, cnt} >= (peff - 17'd1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      acc     <= '0;
      dith    <= 1'b0;
      pwm_out <= 1'b0;
    end else begin
      if (tick) cnt <= boundary ? 16'd0 : cnt + 16'd1;
      if (boundary) begin
        if (act_ctrl.frac) begin
          acc  <= fsum[15:0] & fmask;
          dith <= carry;
        end else begin
          dith <= 1'b0;
        end
      end
      pwm_out <= act_ctrl.en && ({1'b0, cnt} < high);
    end
  end

  p_dark_when_off_r7: assert property (@(posedge clk) disable iff (rst)
    !act_ctrl.en |=> !pwm_out);
  p_no_dither_r8: assert property (@(posedge clk) disable iff (rst)
    (boundary && !act_ctrl.frac) |=> !dith);
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (cnt == 16'd0));

endmodule

// File: rtl/bl_pwm_ctrl.sv
module bl_pwm_ctrl
  import bl_pwm_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             init_req,
  input  logic             master_lock,
  input  logic [PRE_W-1:0] ref_div,
  output logic             pwm_out,
  output logic             upd_pending
);
  logic  tick, boundary;
  ctrl_t act_ctrl;
  per_t  act_per;

  bl_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .ref_div(ref_div), .tick(tick)
  );

  bl_shadow_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .init_req(init_req), .master_lock(master_lock), .tick(tick),
    .boundary(boundary), .act_ctrl(act_ctrl), .act_per(act_per),
    .pending(upd_pending)
  );

  bl_pwm_core u_core (
    .clk(clk), .rst(rst), .tick(tick), .act_ctrl(act_ctrl),
    .act_per(act_per), .boundary(boundary), .pwm_out(pwm_out)
  );

  p_clear_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(upd_pending) |-> $past(tick));

endmodule

// File: tb/bl_pwm_ctrl_tb_top.sv
module bl_pwm_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        init_req = 1'b0;
  logic        master_lock = 1'b0;
  logic [7:0]  ref_div = 8'd0;
  logic        pwm_out, upd_pending;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bl_pwm_ctrl #(.PRE_W(8)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .init_req(init_req), .master_lock(master_lock), .ref_div(ref_div),
    .pwm_out(pwm_out), .upd_pending(upd_pending)
  );

  function automatic logic [31:0] cw(bit en, bit fr, int duty);
    return {en, fr, 14'd0, 16'(duty)};
  endfunction
  function automatic logic [31:0] pw(int bc, int p);
    return {12'd0, 4'(bc), 16'(p)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_init();
    @(negedge clk);
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
  endtask

  task automatic wait_clear(string req);
    int n = 0;
    while (upd_pending && n < 10000) begin
      @(negedge clk);
      n++;
    end
    chk(!upd_pending, req, int'(upd_pending), 0);
  endtask

  task automatic measure(int len, output int hi);
    hi = 0;
    repeat (len) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  task automatic apply(logic [31:0] c, logic [31:0] p, int per_ticks);
    wr(2, 32'd1);
    wr(0, c);
    wr(1, p);
    wr(2, 32'd0);
    wait_clear("R5");
    repeat (2 * per_ticks * (int'(ref_div) + 1) + 4) @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int hi, exp;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!pwm_out && !upd_pending, "R1 in reset", int'({pwm_out, upd_pending}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!pwm_out && !upd_pending, "R1 after reset", int'({pwm_out, upd_pending}), 0);

    // R11: invalid duty with nothing saved -> defaults (full on)
    pulse_init();
    chk(upd_pending, "R11 pending", int'(upd_pending), 1);
    wait_clear("R11");
    repeat (5) @(negedge clk);
    measure(100, hi);
    chk(hi == 100, "R11 default duty", hi, 100);

    // R7 integer sweep, bc=4
    for (int p = 1; p <= 15; p++) begin
      for (int i = 0; i <= 15; i++) begin
        apply(cw(1, 0, i << 12), pw(4, p), p);
        measure(2 * p, hi);
        exp = 2 * ((i < p) ? i : p);
        chk(hi == exp, "R7 integer duty", hi, exp);
      end
    end

    // R8 fractional sweep, bc=12, P=10
    for (int i = 0; i <= 9; i++) begin
      for (int f = 0; f <= 15; f++) begin
        apply(cw(1, 1, (i << 4) | f), pw(12, 10), 10);
        measure(160, hi);
        exp = 16 * i + f;
        chk(hi == exp, "R8 dither total", hi, exp);
      end
    end
    // R7 fraction ignored when fractional mode off
    for (int f = 0; f <= 15; f++) begin
      apply(cw(1, 0, (4 << 4) | f), pw(12, 10), 10);
      measure(160, hi);
      chk(hi == 64, "R7 frac off", hi, 64);
    end

    // R6 period encodings
    apply(cw(1, 0, 5 << 12), pw(4, 0), 15);
    measure(30, hi);
    chk(hi == 10, "R6 zero period", hi, 10);
    apply(cw(1, 0, 2 << 12), pw(4, 16'h0035), 5);
    measure(10, hi);
    chk(hi == 4, "R6 masked period", hi, 4);
    apply(cw(1, 0, 2), pw(0, 3), 3);
    measure(6, hi);
    chk(hi == 4, "R6 bitcount zero means 16", hi, 4);

    // R9 prescaler
    ref_div = 8'd2;
    apply(cw(1, 0, 2 << 12), pw(4, 6), 6);
    measure(36, hi);
    chk(hi == 12, "R9 prescaled duty", hi, 12);
    ref_div = 8'd0;

    // R3 group lock
    apply(cw(1, 0, 3 << 12), pw(4, 8), 8);
    wr(2, 32'd1);
    wr(0, cw(1, 0, 6 << 12));
    chk(upd_pending, "R2 pending after write", int'(upd_pending), 1);
    repeat (40) @(negedge clk);
    chk(upd_pending, "R3 pending held", int'(upd_pending), 1);
    measure(16, hi);
    chk(hi == 6, "R3 old duty kept", hi, 6);
    wr(2, 32'd0);
    wait_clear("R5 after unlock");
    repeat (20) @(negedge clk);
    measure(16, hi);
    chk(hi == 12, "R5 new duty", hi, 12);

    // R4 master lock and ignore bit
    master_lock = 1'b1;
    wr(0, cw(1, 0, 2 << 12));
    repeat (40) @(negedge clk);
    chk(upd_pending, "R4 master blocks", int'(upd_pending), 1);
    measure(16, hi);
    chk(hi == 12, "R4 old duty kept", hi, 12);
    wr(2, 32'd2);
    wait_clear("R4 ignore");
    repeat (20) @(negedge clk);
    measure(16, hi);
    chk(hi == 4, "R4 ignore applies", hi, 4);
    master_lock = 1'b0;
    wr(2, 32'd0);

    // R7 disabled output, R5 idle transfer on next tick
    apply(cw(0, 0, 4 << 12), pw(4, 8), 8);
    measure(16, hi);
    chk(hi == 0, "R7 disabled", hi, 0);
    wr(0, cw(1, 0, 4 << 12));
    chk(upd_pending, "R2 pending", int'(upd_pending), 1);
    @(negedge clk);
    chk(!upd_pending, "R5 idle transfer", int'(upd_pending), 0);

    // R10 save then restore
    apply(cw(1, 0, 3 << 12), pw(4, 8), 8);
    pulse_init();
    chk(!upd_pending, "R10 save no pending", int'(upd_pending), 0);
    wr(0, cw(1, 0, 1));
    pulse_init();
    chk(upd_pending, "R10 restore pending", int'(upd_pending), 1);
    wait_clear("R10");
    repeat (20) @(negedge clk);
    measure(16, hi);
    chk(hi == 6, "R10 restored duty", hi, 6);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule